// File: doc/BRIEF.md
# Plane-Allocating Push-Down Stack Controller

This block runs a push-down stack whose cells are whole storage planes rather than memory words. A stack position is not tied to a fixed plane. Every entry that enters the stack gets a plane picked at run time. That plane is marked busy in a status vector and is tagged with its position in an associative tag register. A depth counter tracks how many entries are live.

Four commands drive the stack: push, complement, OR and AND. For each accepted command the block does four things:

- It looks up the top and next-to-top planes by tag match.
- It picks a fresh destination plane from the planes that the caller marks usable.
- It updates its bookkeeping.
- It emits one registered plane-operation strobe carrying the source planes, the destination plane and the operation code.

The destination is always a plane outside the stack, because the plane datapath cannot read and write one plane in the same operation. A command that cannot be served is refused with a one-cycle depth error. A clear input empties the stack.

Top module: `plane_stack_ctrl`

## Requirements
- R1: After reset or clear, stack_depth is 0, stack_status is 0, and op_valid and depth_err are low.
- R2: The destination plane is the highest-numbered plane whose avail_list bit is 1 and whose stack_status bit is 0.
- R3: A push (cmd_op 2'b00) writes to the allocated plane, sets its status bit and raises stack_depth by one. The new plane becomes the top of the stack. op_src_top and op_src_next report 0 for a push.
- R4: A complement (cmd_op 2'b01) reads the top plane on op_src_top and writes a fresh plane. It clears the old top's status bit and sets the new one. stack_depth is unchanged, and the new plane becomes the top. op_src_next reports 0.
- R5: OR (cmd_op 2'b10) and AND (cmd_op 2'b11) report the top plane on op_src_top and the next-to-top plane on op_src_next, and write a fresh plane. They clear both source status bits, set the destination bit and lower stack_depth by one. The destination becomes the new top.
- R6: The destination plane of every strobed operation was not in the stack before that operation, so it differs from every source plane.
- R7: A command is refused in three cases: no plane can be allocated, a complement arrives with depth 0, or a binary operator arrives with depth below 2. A refused command raises depth_err for one cycle, gives no strobe and leaves stack_depth and stack_status unchanged.
- R8: op_valid is high for exactly one cycle, the cycle after an accepted command. op_code repeats the command code in that cycle.
- R9: Clear takes priority over a command in the same cycle. The command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empties the stack |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 push, 01 complement, 10 OR, 11 AND |
| avail_list | input | 8 | Planes the stack may use |
| op_valid | output | 1 | Plane-operation strobe |
| op_code | output | 2 | Operation of the strobe |
| op_src_top | output | 3 | Top-of-stack source plane |
| op_src_next | output | 3 | Next-to-top source plane |
| op_dst | output | 3 | Destination plane |
| stack_depth | output | 4 | Live entry count |
| stack_status | output | 8 | One bit per plane in the stack |
| depth_err | output | 1 | Command refused |

## Verification
Each command is applied for one clock edge. Every result is due at the next edge and is then held for a full cycle:

- the strobe fields, or the error pulse;
- the updated depth;
- the updated status vector.

The bench drives on the falling edge and samples at the following falling edge. It compares against a model that it advances once per command. A stack with wrong tag ordering cannot hide, because it shows up as wrong source planes on a later complement or binary operator.

// File: rtl/pstack_pkg.sv
package pstack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_NOT  = 2'b01,
    OP_OR   = 2'b10,
    OP_AND  = 2'b11
  } pop_e;
endpackage

// File: rtl/psc_alloc.sv
// Picks the highest-numbered usable plane that is not in the stack.
module psc_alloc #(
  parameter int NP = 8,
  localparam int IW = $clog2(NP)
) (
  input  logic [NP-1:0] avail,
  input  logic [NP-1:0] busy,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NP; i++) begin
      if (avail[i] && !busy[i]) begin
        found = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/psc_locate.sv
// Associative lookup: which live plane carries the given tag.
module psc_locate #(
  parameter int NP = 8,
  localparam int TW = $clog2(NP)
) (
  input  logic [NP-1:0]    live,
  input  logic [NP*TW-1:0] tags,
  input  logic [TW-1:0]    key,
  output logic             hit,
  output logic [TW-1:0]    idx
);
  logic [NP-1:0] match;

  for (genvar g = 0; g < NP; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g*TW +: TW] == key);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = 0; i < NP; i++) begin
      if (match[i]) idx = i[TW-1:0];
    end
  end
endmodule

// File: rtl/plane_stack_ctrl.sv
module plane_stack_ctrl #(
  parameter int NP = 8,
  localparam int TW = $clog2(NP),
  localparam int CW = $clog2(NP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [NP-1:0] avail_list,
  output logic          op_valid,
  output logic [1:0]    op_code,
  output logic [TW-1:0] op_src_top,
  output logic [TW-1:0] op_src_next,
  output logic [TW-1:0] op_dst,
  output logic [CW-1:0] stack_depth,
  output logic [NP-1:0] stack_status,
  output logic          depth_err
);
  import pstack_pkg::*;

  logic [CW-1:0]    depth_q;
  logic [NP-1:0]    sr_q;
  logic [TW-1:0]    aar_q [NP];
  logic [NP*TW-1:0] aar_flat;

  for (genvar g = 0; g < NP; g++) begin : g_pack
    assign aar_flat[g*TW +: TW] = aar_q[g];
  end

  // Tags searched for: index 0 is the top, index 1 the next-to-top
  logic [CW-1:0] dm1, dm2;
  logic [TW-1:0] keys [2];
  logic [1:0]    hits;
  logic [TW-1:0] hidx [2];

  assign dm1     = depth_q - CW'(1);
  assign dm2     = depth_q - CW'(2);
  assign keys[0] = dm1[TW-1:0];
  assign keys[1] = dm2[TW-1:0];

  for (genvar k = 0; k < 2; k++) begin : g_loc
    psc_locate #(.NP(NP)) u_loc (
      .live(sr_q), .tags(aar_flat), .key(keys[k]),
      .hit(hits[k]), .idx(hidx[k])
    );
  end

  logic          al_found;
  logic [TW-1:0] al_idx;

  psc_alloc #(.NP(NP)) u_alloc (
    .avail(avail_list), .busy(sr_q), .found(al_found), .idx(al_idx)
  );

  pop_e op;
  logic accept;

  always_comb begin
    op = pop_e'(cmd_op);
    unique case (op)
      OP_PUSH: accept = al_found;
      OP_NOT:  accept = al_found && (depth_q >= CW'(1)) && hits[0];
      default: accept = al_found && (depth_q >= CW'(2)) && hits[0] && hits[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      depth_q     <= '0;
      sr_q        <= '0;
      for (int i = 0; i < NP; i++) aar_q[i] <= '0;
      op_valid    <= 1'b0;
      op_code     <= '0;
      op_src_top  <= '0;
      op_src_next <= '0;
      op_dst      <= '0;
      depth_err   <= 1'b0;
    end else begin
      op_valid  <= 1'b0;
      depth_err <= 1'b0;
      if (cmd_valid) begin
        if (accept) begin
          op_valid    <= 1'b1;
          op_code     <= cmd_op;
          op_dst      <= al_idx;
          op_src_top  <= (op == OP_PUSH) ? '0 : hidx[0];
          op_src_next <= (op == OP_OR || op == OP_AND) ? hidx[1] : '0;
          unique case (op)
            OP_PUSH: begin
              sr_q[al_idx]  <= 1'b1;
              aar_q[al_idx] <= depth_q[TW-1:0];
              depth_q       <= depth_q + CW'(1);
            end
            OP_NOT: begin
              sr_q[hidx[0]] <= 1'b0;
              sr_q[al_idx]  <= 1'b1;
              aar_q[al_idx] <= keys[0];
            end
            default: begin
              sr_q[hidx[0]] <= 1'b0;
              sr_q[hidx[1]] <= 1'b0;
              sr_q[al_idx]  <= 1'b1;
              aar_q[al_idx] <= keys[1];
              depth_q       <= depth_q - CW'(1);
            end
          endcase
        end else begin
          depth_err <= 1'b1;
        end
      end
    end
  end

  assign stack_depth  = depth_q;
  assign stack_status = sr_q;

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (depth_q == '0 && sr_q == '0 && !op_valid)); // R1 R9
  AST_DEPTH_COUNT: assert property (@(posedge clk) disable iff (rst)
    depth_q == CW'($countones(sr_q))); // R3
  AST_BIN_SHRINK: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code[1]) |-> depth_q == $past(depth_q) - CW'(1)); // R5
  AST_DST_FRESH: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> ((($past(sr_q) >> op_dst) & NP'(1)) == '0)); // R6
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    depth_err |-> (!op_valid && $stable(sr_q) && $stable(depth_q))); // R7
  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> $past(cmd_valid)); // R8
endmodule

// File: tb/plane_stack_ctrl_bench.sv
module plane_stack_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] avail_list = 8'hFF;
  logic       op_valid;
  logic [1:0] op_code;
  logic [2:0] op_src_top, op_src_next, op_dst;
  logic [3:0] stack_depth;
  logic [7:0] stack_status;
  logic       depth_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference model
  logic [7:0] m_sr = 8'h00;
  int         m_tag [8];
  int         m_depth = 0;

  always #10 clk = ~clk;

  plane_stack_ctrl u_plane_stack_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .avail_list(avail_list), .op_valid(op_valid), .op_code(op_code),
    .op_src_top(op_src_top), .op_src_next(op_src_next), .op_dst(op_dst),
    .stack_depth(stack_depth), .stack_status(stack_status), .depth_err(depth_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int f_alloc(logic [7:0] av);
    int r = -1;
    for (int i = 0; i < 8; i++) if (av[i] && !m_sr[i]) r = i;
    return r;
  endfunction

  function automatic int f_find(int key);
    int r = -1;
    for (int i = 0; i < 8; i++) if (m_sr[i] && m_tag[i] == key) r = i;
    return r;
  endfunction

  task automatic check_state(string req);
    chk(req, "depth", int'(stack_depth), m_depth);
    chk(req, "status", int'(stack_status), int'(m_sr));
  endtask

  // called on a falling edge; returns on the falling edge after the result
  task automatic do_cmd(int op, logic [7:0] av, bit c);
    int  al, tp, nx;
    bit  ok;
    string rq;
    al = f_alloc(av);
    tp = f_find(m_depth - 1);
    nx = f_find(m_depth - 2);
    case (op)
      0: begin ok = (al >= 0);                                rq = "R3"; end
      1: begin ok = (al >= 0) && m_depth >= 1;                rq = "R4"; end
      default: begin ok = (al >= 0) && m_depth >= 2;          rq = "R5"; end
    endcase
    cmd_valid = 1'b1; cmd_op = op[1:0]; avail_list = av; clr = c;
    @(negedge clk);
    cmd_valid = 1'b0; clr = 1'b0;
    if (c) begin
      m_sr = 8'h00; m_depth = 0;
      chk("R9", "strobe on clear", int'(op_valid), 0);
      chk("R9", "err on clear", int'(depth_err), 0);
      check_state("R1");
    end else if (!ok) begin
      chk("R7", "err", int'(depth_err), 1);
      chk("R7", "strobe", int'(op_valid), 0);
      check_state("R7");
    end else begin
      chk("R8", "strobe", int'(op_valid), 1);
      chk("R8", "code", int'(op_code), op);
      chk("R2", "dst", int'(op_dst), al);
      chk("R6", "dst fresh", int'(m_sr[al]), 0);
      case (op)
        0: begin
          chk(rq, "src_top", int'(op_src_top), 0);
          chk(rq, "src_next", int'(op_src_next), 0);
          m_sr[al] = 1'b1; m_tag[al] = m_depth; m_depth++;
        end
        1: begin
          chk(rq, "src_top", int'(op_src_top), tp);
          chk(rq, "src_next", int'(op_src_next), 0);
          m_sr[tp] = 1'b0; m_sr[al] = 1'b1; m_tag[al] = m_depth - 1;
        end
        default: begin
          chk(rq, "src_top", int'(op_src_top), tp);
          chk(rq, "src_next", int'(op_src_next), nx);
          m_sr[tp] = 1'b0; m_sr[nx] = 1'b0; m_sr[al] = 1'b1;
          m_tag[al] = m_depth - 2; m_depth--;
        end
      endcase
      check_state(rq);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R8", "idle strobe", int'(op_valid), 0);
    chk("R7", "idle err", int'(depth_err), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m_tag[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset strobe", int'(op_valid), 0);
    chk("R1", "reset err", int'(depth_err), 0);
    check_state("R1");

    // directed corners
    do_cmd(2, 8'hFF, 1'b0);          // OR on empty stack: refused (R7)
    do_cmd(1, 8'hFF, 1'b0);          // complement on empty stack (R7)
    do_cmd(0, 8'h00, 1'b0);          // nothing usable (R7)
    do_cmd(0, 8'hFF, 1'b0);
    chk("R2", "first plane is 7", int'(op_dst), 7);
    do_cmd(3, 8'hFF, 1'b0);          // AND with depth 1 (R7)
    do_cmd(0, 8'h5A, 1'b0);
    chk("R2", "masked pick is 6", int'(op_dst), 6);
    do_cmd(1, 8'hFF, 1'b0);
    chk("R4", "complement of 6 into 5", int'(op_src_top), 6);
    do_cmd(2, 8'hFF, 1'b0);
    chk("R5", "OR next-to-top is 7", int'(op_src_next), 7);
    idle_check();
    for (int i = 0; i < 8; i++) do_cmd(0, 8'hFF, 1'b0); // fill, then refuse
    do_cmd(3, 8'hFF, 1'b1);          // clear wins over a command (R9)
    idle_check();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      int r, op;
      logic [7:0] av;
      r  = $urandom % 100;
      op = (r < 40) ? 0 : (r < 60) ? 1 : (r < 80) ? 2 : 3;
      av = ($urandom % 6 == 0) ? 8'($urandom) : 8'hFF;
      do_cmd(op, av, ($urandom % 60) == 0);
      if ($urandom % 10 == 0) idle_check();
    end
    finish_run();
  end
endmodule